// File: doc/BRIEF.md
# Layer-by-layer tracklet road finder

This block collects one event's worth of packed detector hit words and groups them into tracklets. Each valid hit is placed in an occupancy store that is addressed by layer and by a global tube position, and is tagged with a hit index equal to its order of acceptance. When the event is closed, the block scans the innermost layer in ascending position. Every hit it finds there starts a new tracklet. The tracklet then grows outward one layer at a time: at each step the block looks in the next layer for a free hit in a small window of neighbouring tubes.

The size of the window depends on the type of the layer the tracklet currently ends in. Axial layers offer four candidate tubes and stereo layers offer six. Tube positions wrap around the ring of segments, so a search that runs off the edge of one segment continues in the adjacent segment. Once a hit has joined a tracklet it is removed from the store and cannot be taken again. The result leaves the block as a stream of one hit index per cycle, with a tracklet number and a flag on the final hit of each tracklet, followed by a one-cycle done pulse.

Top module: `rf_road_finder`

## Requirements
- R1: A hit word is decoded as segment in bits [28:26], layer in bits [25:22] and tube in bits [21:16]. Bits [15:0] carry the arrival time and do not affect the result. Each accepted hit gets an index equal to the number of hits accepted before it in the event, starting at 0.
- R2: After `evt_close`, tracklets start only from layer-0 hits. Each layer-0 hit starts exactly one tracklet, and tracklets are started in ascending global position, where global position = segment*TUBES + tube.
- R3: A tracklet is emitted as one beat per hit, in consecutive cycles and in strictly increasing layer order, with each step going from layer L to layer L+1.
- R4: From a hit in an axial layer, the next-layer candidates are global position offsets 0, +1, -1 and +2, tried in that priority order. The first free candidate is attached.
- R5: From a hit in a stereo layer (bit L of `STEREO_MASK` set, default layers 2 to 5), the candidates are offsets 0, +1, -1, +2, -2 and +3, tried in that order.
- R6: Candidate positions wrap modulo N_SEG*TUBES. Stepping past the last tube of a segment reaches tube 0 of the next segment, stepping below tube 0 reaches the last tube of the previous segment, and the last segment is adjacent to segment 0.
- R7: A tracklet closes with `trk_end`=1 on a beat whose hit has no free candidate, or whose hit is in the outermost layer. Tracklets are numbered on `trk_id` from 0 upward within an event.
- R8: A hit that has been attached to one tracklet is never attached to another.
- R9: A hit word is ignored and uses no index if its layer is N_LAYERS or above, its tube is TUBES or above, its cell is already occupied, MAX_HITS hits have already been accepted, or it arrives between `evt_close` and `evt_done`.
- R10: `evt_done` pulses for one cycle after the last beat, or after the scan when no tracklet is emitted. The store and the hit index are then cleared for the next event. After reset, `trk_valid` and `evt_done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hit_valid | input | 1 | `hit_word` is present this cycle |
| hit_word | input | 29 | Packed hit: segment, layer, tube, arrival time |
| evt_close | input | 1 | Ends hit loading and starts road finding |
| trk_valid | output | 1 | A tracklet hit beat is present |
| trk_id | output | 7 | Tracklet number within the event |
| trk_hit | output | 7 | Index of the hit in this beat |
| trk_end | output | 1 | This beat is the last hit of its tracklet |
| evt_done | output | 1 | One-cycle pulse when the event is finished |

## Verification
The main function is driven with several kinds of input:
- A straight chain through every layer, which separates correct layer stepping and correct indexing from early closure.
- A sweep of next-layer offsets from -3 to +4, starting from both an axial layer and a stereo layer. This shows exactly which offsets each window accepts.
- Placements across the ring seam, which tell a true modulo wrap from a clamp.
- Two-candidate and shared-hit layouts, which expose the priority order and the no-reuse rule.
- Rejected words, overflow past the hit limit and hits injected while the event is being processed, which show that nothing spurious enters the store.
- Dense pseudo-random events near the seam, checked against an arithmetic greedy model.

// File: rtl/rf_pkg.sv
package rf_pkg;
  localparam int SEG_W  = 3;
  localparam int LAY_W  = 4;
  localparam int TUBE_W = 6;
  localparam int TIME_W = 16;
  localparam int WORD_W = SEG_W + LAY_W + TUBE_W + TIME_W;

  localparam int N_CAND       = 6;
  localparam int N_CAND_AXIAL = 4;

  typedef enum logic [1:0] {ST_LOAD, ST_SCAN, ST_EMIT, ST_FIN} rf_state_e;

  typedef struct packed {
    logic [SEG_W-1:0]  seg;
    logic [LAY_W-1:0]  layer;
    logic [TUBE_W-1:0] tube;
    logic [TIME_W-1:0] stamp;
  } rf_word_t;

  // candidate offset by priority rank; the first N_CAND_AXIAL serve axial layers
  function automatic int cand_offset(input int k);
    case (k)
      0:       return 0;
      1:       return 1;
      2:       return -1;
      3:       return 2;
      4:       return -2;
      default: return 3;
    endcase
  endfunction
endpackage

// File: rtl/rf_hit_decode.sv
module rf_hit_decode
  import rf_pkg::*;
#(
  parameter int N_SEG    = 8,
  parameter int TUBES    = 8,
  parameter int N_LAYERS = 8,
  parameter int POS_W    = 6,
  parameter int LAYI_W   = 3
) (
  input  logic [WORD_W-1:0] word,
  output logic [LAYI_W-1:0] layer,
  output logic [POS_W-1:0]  pos,
  output logic              ok
);
  rf_word_t w;
  logic     unused_stamp_bits;

  assign w                 = word;
  assign unused_stamp_bits = ^w.stamp;

  always_comb begin
    int p;
    p     = int'(w.seg) * TUBES + int'(w.tube);
    pos   = POS_W'(p);
    layer = LAYI_W'(w.layer);
    ok    = (int'(w.seg) < N_SEG) && (int'(w.layer) < N_LAYERS) && (int'(w.tube) < TUBES);
  end
endmodule

// File: rtl/rf_occ_store.sv
module rf_occ_store #(
  parameter int N_CELLS = 512,
  parameter int CELL_W  = 9,
  parameter int IDX_W   = 7
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clear_all,
  input  logic               set_en,
  input  logic [CELL_W-1:0]  set_addr,
  input  logic [IDX_W-1:0]   set_idx,
  input  logic               take_en,
  input  logic [CELL_W-1:0]  take_addr,
  output logic [IDX_W-1:0]   take_idx,
  output logic [N_CELLS-1:0] occ
);
  logic [IDX_W-1:0] idx_mem [N_CELLS];

  // occupancy bits: set on load, cleared when a hit is taken
  always_ff @(posedge clk) begin
    if (rst || clear_all) begin
      occ <= '0;
    end else begin
      if (set_en)  occ[set_addr]  <= 1'b1;
      if (take_en) occ[take_addr] <= 1'b0;
    end
  end

  // index memory: one write port, one registered read port
  always_ff @(posedge clk) begin
    if (set_en)  idx_mem[set_addr] <= set_idx;
    if (take_en) take_idx <= idx_mem[take_addr];
  end

  assert_take_occupied_R8: assert property (@(posedge clk) disable iff (rst)
    take_en |-> occ[take_addr]);

  assert_take_clears_R8: assert property (@(posedge clk) disable iff (rst)
    take_en && !clear_all |=> !occ[$past(take_addr)]);
endmodule

// File: rtl/rf_neighbour_pick.sv
module rf_neighbour_pick
  import rf_pkg::*;
#(
  parameter int N_POS = 64,
  parameter int POS_W = 6
) (
  input  logic [N_POS-1:0] row,
  input  logic [POS_W-1:0] base,
  input  logic             stereo,
  input  logic             allow,
  output logic             found,
  output logic [POS_W-1:0] pick
);
  logic [N_CAND-1:0]       cand_hit;
  logic [N_CAND*POS_W-1:0] cand_pos;

  function automatic logic [POS_W-1:0] ring_pos(input int b, input int off);
    int t;
    t = b + off;
    if (t < 0)           t = t + N_POS;
    else if (t >= N_POS) t = t - N_POS;
    return POS_W'(t);
  endfunction

  for (genvar k = 0; k < N_CAND; k++) begin : g_cand
    localparam int   OFF   = cand_offset(k);
    localparam logic IN_AX = (k < N_CAND_AXIAL);
    logic [POS_W-1:0] p;
    assign p = ring_pos(int'(base), OFF);
    assign cand_pos[k*POS_W +: POS_W] = p;
    assign cand_hit[k] = allow && row[p] && (IN_AX || stereo);
  end

  // lowest rank wins
  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int k = N_CAND - 1; k >= 0; k--) begin
      if (cand_hit[k]) begin
        found = 1'b1;
        pick  = cand_pos[k*POS_W +: POS_W];
      end
    end
  end

  always_comb begin
    if (!stereo) assert_axial_window_R4: assert (cand_hit[N_CAND-1:N_CAND_AXIAL] == '0);
  end
endmodule

// File: rtl/rf_road_finder.sv
module rf_road_finder
  import rf_pkg::*;
#(
  parameter int          N_SEG       = 8,
  parameter int          TUBES       = 8,
  parameter int          N_LAYERS    = 8,
  parameter int          MAX_HITS    = 128,
  parameter logic [15:0] STEREO_MASK = 16'h003C
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          hit_valid,
  input  logic [28:0]                   hit_word,
  input  logic                          evt_close,
  output logic                          trk_valid,
  output logic [$clog2(MAX_HITS)-1:0]   trk_id,
  output logic [$clog2(MAX_HITS)-1:0]   trk_hit,
  output logic                          trk_end,
  output logic                          evt_done
);
  localparam int N_POS   = N_SEG * TUBES;
  localparam int POS_W   = $clog2(N_POS);
  localparam int N_CELLS = N_LAYERS * N_POS;
  localparam int CELL_W  = $clog2(N_CELLS);
  localparam int LAYI_W  = (N_LAYERS > 1) ? $clog2(N_LAYERS) : 1;
  localparam int IDX_W   = $clog2(MAX_HITS);
  localparam int CNT_W   = $clog2(MAX_HITS + 1);

  function automatic logic [CELL_W-1:0] cell_of(input int lay, input logic [POS_W-1:0] p);
    return CELL_W'(lay * N_POS + int'(p));
  endfunction

  rf_state_e          state;
  logic [POS_W-1:0]   scan_ptr;
  logic [POS_W-1:0]   cur_pos;
  logic [LAYI_W-1:0]  cur_layer;
  logic [CNT_W-1:0]   hit_cnt;
  logic [IDX_W-1:0]   tid;

  logic [LAYI_W-1:0]  d_layer;
  logic [POS_W-1:0]   d_pos;
  logic               d_ok;
  logic [CELL_W-1:0]  d_cell;
  logic               accept;

  logic [N_CELLS-1:0] occ_all;
  logic [IDX_W-1:0]   take_idx;
  logic               take_en;
  logic [CELL_W-1:0]  take_addr;

  logic               scan_hit;
  logic               scan_last;
  logic               nxt_ok;
  logic [N_POS-1:0]   nxt_row;
  logic               cur_stereo;
  logic               found;
  logic [POS_W-1:0]   pick_pos;

  rf_hit_decode #(
    .N_SEG(N_SEG), .TUBES(TUBES), .N_LAYERS(N_LAYERS), .POS_W(POS_W), .LAYI_W(LAYI_W)
  ) u_decode (
    .word (hit_word),
    .layer(d_layer),
    .pos  (d_pos),
    .ok   (d_ok)
  );

  assign d_cell = cell_of(int'(d_layer), d_pos);
  assign accept = (state == ST_LOAD) && hit_valid && d_ok && !occ_all[d_cell]
                  && (int'(hit_cnt) < MAX_HITS);

  assign scan_hit   = occ_all[cell_of(0, scan_ptr)];
  assign scan_last  = (scan_ptr == POS_W'(N_POS - 1));
  assign nxt_ok     = (int'(cur_layer) < N_LAYERS - 1);
  assign cur_stereo = STEREO_MASK[cur_layer];

  always_comb begin
    nxt_row = '0;
    if (nxt_ok) nxt_row = occ_all[(int'(cur_layer) + 1) * N_POS +: N_POS];
  end

  rf_neighbour_pick #(.N_POS(N_POS), .POS_W(POS_W)) u_pick (
    .row   (nxt_row),
    .base  (cur_pos),
    .stereo(cur_stereo),
    .allow (nxt_ok),
    .found (found),
    .pick  (pick_pos)
  );

  assign take_en   = ((state == ST_SCAN) && scan_hit) || ((state == ST_EMIT) && found);
  assign take_addr = (state == ST_SCAN) ? cell_of(0, scan_ptr)
                                        : cell_of(int'(cur_layer) + 1, pick_pos);

  rf_occ_store #(.N_CELLS(N_CELLS), .CELL_W(CELL_W), .IDX_W(IDX_W)) u_store (
    .clk      (clk),
    .rst      (rst),
    .clear_all(state == ST_FIN),
    .set_en   (accept),
    .set_addr (d_cell),
    .set_idx  (hit_cnt[IDX_W-1:0]),
    .take_en  (take_en),
    .take_addr(take_addr),
    .take_idx (take_idx),
    .occ      (occ_all)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_LOAD;
      scan_ptr  <= '0;
      cur_pos   <= '0;
      cur_layer <= '0;
      hit_cnt   <= '0;
      tid       <= '0;
      trk_valid <= 1'b0;
      trk_id    <= '0;
      trk_hit   <= '0;
      trk_end   <= 1'b0;
      evt_done  <= 1'b0;
    end else begin
      trk_valid <= 1'b0;
      trk_end   <= 1'b0;
      evt_done  <= 1'b0;
      case (state)
        ST_LOAD: begin
          if (accept) hit_cnt <= hit_cnt + 1'b1;
          if (evt_close) begin
            scan_ptr <= '0;
            state    <= ST_SCAN;
          end
        end
        ST_SCAN: begin
          if (scan_hit) begin
            cur_layer <= '0;
            cur_pos   <= scan_ptr;
            state     <= ST_EMIT;
          end else if (scan_last) begin
            state <= ST_FIN;
          end else begin
            scan_ptr <= scan_ptr + 1'b1;
          end
        end
        ST_EMIT: begin
          trk_valid <= 1'b1;
          trk_hit   <= take_idx;
          trk_id    <= tid;
          trk_end   <= !found;
          if (found) begin
            cur_layer <= cur_layer + 1'b1;
            cur_pos   <= pick_pos;
          end else begin
            tid <= tid + 1'b1;
            if (scan_last) begin
              state <= ST_FIN;
            end else begin
              scan_ptr <= scan_ptr + 1'b1;
              state    <= ST_SCAN;
            end
          end
        end
        default: begin
          evt_done <= 1'b1;
          hit_cnt  <= '0;
          tid      <= '0;
          state    <= ST_LOAD;
        end
      endcase
    end
  end

  assert_beats_back_to_back_R3: assert property (@(posedge clk) disable iff (rst)
    trk_valid && !trk_end |=> trk_valid);

  assert_gap_after_close_R7: assert property (@(posedge clk) disable iff (rst)
    trk_valid && trk_end |=> !trk_valid);

  assert_done_single_R10: assert property (@(posedge clk) disable iff (rst)
    evt_done |=> !evt_done);

  assert_layer0_drained_R2: assert property (@(posedge clk) disable iff (rst)
    state == ST_FIN |-> occ_all[N_POS-1:0] == '0);

  assert_no_load_when_busy_R9: assert property (@(posedge clk) disable iff (rst)
    state != ST_LOAD |=> $stable(hit_cnt) || evt_done || $past(state) == ST_FIN);
endmodule

// File: tb/rf_road_finder_tb_top.sv
module rf_road_finder_tb_top;
  localparam int N_SEG = 8;
  localparam int TUBES = 8;
  localparam int NL    = 8;
  localparam int NP    = N_SEG * TUBES;
  localparam int MAXH  = 128;
  localparam logic [15:0] STEREO = 16'h003C;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        hit_valid = 1'b0;
  logic [28:0] hit_word = '0;
  logic        evt_close = 1'b0;
  logic        trk_valid, trk_end, evt_done;
  logic [6:0]  trk_id, trk_hit;

  always #4 clk = ~clk;

  rf_road_finder dut_i (
    .clk(clk), .rst(rst), .hit_valid(hit_valid), .hit_word(hit_word),
    .evt_close(evt_close), .trk_valid(trk_valid), .trk_id(trk_id),
    .trk_hit(trk_hit), .trk_end(trk_end), .evt_done(evt_done)
  );

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [15:0] lfsr = 16'hACE1;

  bit m_occ [NL][NP];
  int m_idx [NL][NP];
  int m_cnt = 0;

  int e_n, got_n;
  int e_id [256]; int e_hit [256]; int e_end [256];
  int g_id [256]; int g_hit [256]; int g_end [256];
  bit collecting = 0;
  bit done_seen  = 0;

  int offs [6] = '{0, 1, -1, 2, -2, 3};

  always @(posedge clk) begin
    cycles <= cycles + 1;
    lfsr   <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  end

  always @(negedge clk) begin
    if (collecting && trk_valid && got_n < 256) begin
      g_id[got_n]  = int'(trk_id);
      g_hit[got_n] = int'(trk_hit);
      g_end[got_n] = int'(trk_end);
      got_n++;
    end
    if (collecting && evt_done) done_seen = 1;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic put(input int seg, input int layer, input int tube);
    @(posedge clk); #1;
    hit_valid = 1'b1;
    hit_word  = {3'(seg), 4'(layer), 6'(tube), lfsr};
    @(posedge clk); #1;
    hit_valid = 1'b0;
    if (seg < N_SEG && layer < NL && tube < TUBES) begin
      int p;
      p = seg * TUBES + tube;
      if (!m_occ[layer][p] && m_cnt < MAXH) begin
        m_occ[layer][p] = 1;
        m_idx[layer][p] = m_cnt;
        m_cnt++;
      end
    end
  endtask

  task automatic put_pos(input int layer, input int pos);
    int q;
    q = ((pos % NP) + NP) % NP;
    put(q / TUBES, layer, q % TUBES);
  endtask

  // greedy reference built from R2..R8
  task automatic model_expect();
    int tid;
    e_n = 0; tid = 0;
    for (int p = 0; p < NP; p++) begin
      if (m_occ[0][p]) begin
        int l, cp;
        bit more;
        m_occ[0][p] = 0; l = 0; cp = p; more = 1;
        while (more) begin
          bit fnd;
          int q, nc;
          fnd = 0; q = 0;
          if (l < NL - 1) begin
            nc = STEREO[l] ? 6 : 4;
            for (int k = 0; k < nc; k++) begin
              int c;
              c = (cp + offs[k] + NP) % NP;
              if (!fnd && m_occ[l+1][c]) begin fnd = 1; q = c; end
            end
          end
          e_id[e_n] = tid; e_hit[e_n] = m_idx[l][cp]; e_end[e_n] = fnd ? 0 : 1;
          e_n++;
          if (fnd) begin m_occ[l+1][q] = 0; l++; cp = q; end
          else more = 0;
        end
        tid++;
      end
    end
    for (int l = 0; l < NL; l++) for (int p = 0; p < NP; p++) m_occ[l][p] = 0;
    m_cnt = 0;
  endtask

  task automatic run(input string tag, input bit inject);
    int w;
    got_n = 0; done_seen = 0; collecting = 1;
    @(posedge clk); #1; evt_close = 1'b1;
    @(posedge clk); #1; evt_close = 1'b0;
    if (inject) begin
      hit_valid = 1'b1;
      hit_word  = {3'(60 / TUBES), 4'(1), 6'(60 % TUBES), lfsr};
      @(posedge clk); #1; hit_valid = 1'b0;
    end
    w = 0;
    while (!done_seen && w < 3000) begin @(posedge clk); w++; end
    @(negedge clk);
    collecting = 0;
    model_expect();
    chk(done_seen, {tag, " done pulse (R10)"}, int'(done_seen), 1);
    chk(got_n == e_n, {tag, " beat count"}, got_n, e_n);
    for (int i = 0; i < got_n && i < e_n; i++)
      chk(g_id[i] == e_id[i] && g_hit[i] == e_hit[i] && g_end[i] == e_end[i],
          {tag, " beat id*512+hit*2+end"},
          g_id[i] * 512 + g_hit[i] * 2 + g_end[i], e_id[i] * 512 + e_hit[i] * 2 + e_end[i]);
  endtask

  initial begin
    wait (cycles > 150000);
    errors++;
    $display("FAIL R10 watchdog: cycles %0d expected below 150000", cycles);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk(trk_valid == 1'b0, "R10 reset trk_valid", int'(trk_valid), 0);
    chk(evt_done == 1'b0, "R10 reset evt_done", int'(evt_done), 0);

    run("R10 empty event", 0);

    for (int l = 0; l < NL; l++) put_pos(l, 5);
    run("R1 R3 R7 straight chain", 0);

    for (int off = -3; off <= 4; off++) begin
      put_pos(0, 20); put_pos(1, 20 + off);
      run($sformatf("R4 axial offset %0d", off), 0);
    end
    for (int off = -3; off <= 4; off++) begin
      put_pos(0, 20); put_pos(1, 20); put_pos(2, 20); put_pos(3, 20 + off);
      run($sformatf("R5 stereo offset %0d", off), 0);
    end

    put(7, 0, 7); put(0, 1, 0);
    run("R6 wrap last to first segment", 0);
    put(3, 0, 0); put(2, 1, 7);
    run("R6 wrap to lower segment", 0);
    put(0, 0, 0); put(0, 1, 0); put(0, 2, 0); put(7, 3, 6);
    run("R6 stereo wrap -2", 0);

    put_pos(1, 9); put_pos(1, 10); put_pos(1, 11); put_pos(0, 10);
    run("R4 priority centre first", 0);
    put_pos(1, 9); put_pos(1, 11); put_pos(0, 10);
    run("R4 priority +1 over -1", 0);

    put_pos(0, 10); put_pos(0, 11); put_pos(1, 11); put_pos(2, 11);
    run("R8 shared hit taken once", 0);

    put(0, 0, 8); put(0, 8, 3); put(0, 0, 3); put(0, 0, 3); put(0, 1, 3);
    run("R9 rejected words", 0);

    for (int i = 0; i < 130; i++) put_pos(i / NP, i % NP);
    run("R9 overflow past MAX_HITS", 0);

    put_pos(0, 60);
    run("R9 hit while busy", 1);

    for (int ev = 0; ev < 6; ev++) begin
      for (int h = 0; h < 40; h++) begin
        int lay, pos;
        lay = int'(lfsr[3:0]) % 9;
        pos = 58 + int'(lfsr[11:4]) % 12;
        put_pos(lay, pos);
      end
      run($sformatf("R6 R8 dense event %0d", ev), 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule